// File: doc/BRIEF.md
# ADC Conversion Mode Sequencer

This block is the digital control sequencer of a multi-channel successive-approximation converter. Software programs a 2-bit mode field, a channel number and a start bit through a single write strobe. The sequencer then walks the converter through fixed-channel or auto-scan conversions, once or continuously. Auto-scan always counts down from the programmed channel to channel 0. An external compare event can request an injected conversion of a separately supplied channel at any time. The injected result goes to its own result register and raises its own completion pulse. Standard results go to the standard result register.

Each conversion is a fixed-latency step. While a conversion runs, the block presents the selected channel on `conv_chan`. It captures the front-end code `sample_in` on the last cycle. The stored result word is the channel number in the upper bits with the code below it. A mode written during a conversion is used once that conversion ends. A channel or start written during a sequence is used only at the sequence boundary. An injection request sits in a latch that only its own service clears, so a software start never aborts or drops it.

Top module: `adc_seq_top`

## Requirements
- R1: While reset is held, `busy`, `inj_req`, `start_flag`, `eoc_irq`, `eoi_irq` and both result registers are 0.
- R2: With mode 00 (fixed single), a start converts the programmed channel exactly once. It stores `{channel, code}` in `std_result`, pulses `eoc_irq` for one cycle, then clears `start_flag` and drops `busy`.
- R3: Counted from idle, `eoc_irq` appears exactly CONV_CYC cycles after `busy` rises.
- R4: With mode 10 (auto-scan single), a start at channel n converts n, n-1, … 0 in that order. The block then goes idle with `start_flag` cleared.
- R5: Mode 01 (fixed continuous) and mode 11 (scan continuous) repeat the sequence while start stays 1. Once start is written 0, the current fixed conversion finishes and the block stops. In scan, the current sequence runs down to channel 0 before the block stops.
- R6: If the mode changes to auto-scan while a fixed conversion of channel n runs, channels n-1 down to 0 follow it.
- R7: A channel and start written during a fixed conversion are used after that conversion. When written during an auto-scan, they are used only after channel 0. A start written 1 during a sequence launches one further sequence at that boundary.
- R8: Writing any mode with start 0 while idle starts no conversion.
- R9: An injected conversion stores `{inj_chan, code}` in `inj_result` and pulses `eoi_irq`. `std_result` is left unchanged.
- R10: `inj_req` is high from the cycle after the trigger until the injected result is stored. `busy` is high throughout any conversion.
- R11: A trigger that lands while a standard conversion is running, or on the cycle it ends, is converted right after that conversion. The standard scan then resumes at the next channel with nothing skipped.
- R12: A software start during an injected conversion does not shorten it. The injection completes CONV_CYC cycles after it began, and the standard conversion follows it.
- R13: A trigger during a running injected conversion queues one more injected conversion after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Mode: 00 fixed single, 01 fixed continuous, 10 scan single, 11 scan continuous |
| cfg_chan | input | CH_W | Programmed channel |
| cfg_start | input | 1 | Start bit |
| inj_trig | input | 1 | Injection request pulse from compare event |
| inj_chan | input | CH_W | Channel for injected conversion |
| sample_in | input | RES_W | Front-end code of the selected channel |
| conv_chan | output | CH_W | Channel being converted |
| busy | output | 1 | A conversion is in progress |
| inj_req | output | 1 | Injection pending or running |
| start_flag | output | 1 | Start bit as currently held |
| std_result | output | CH_W+RES_W | Last standard result {channel, code} |
| inj_result | output | CH_W+RES_W | Last injected result {channel, code} |
| eoc_irq | output | 1 | One-cycle end-of-conversion pulse |
| eoi_irq | output | 1 | One-cycle end-of-injection pulse |

## Verification
Fixed single starts on different channels expose a wrong channel tag, a wrong code or the wrong latency. Down-counting scans from several start channels show skipped, repeated or reordered channels. Writes placed in the middle of a fixed conversion or a scan tell a boundary-deferred update from an immediate one. An idle write of a scan mode with start 0 catches the spurious scan. Triggers are placed in the middle of a conversion, exactly on the boundary cycle, during a running injection and ahead of a software start, and the completion times are compared. These cases tell a lost or aborted injection, and a standard start stalled behind one, from the intended ordering. Random fixed and scan starts with randomly timed injections mix these cases.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_STD  = 2'd1,
    ST_INJ  = 2'd2
  } seq_state_e;

  localparam int MODE_CONT = 0;
  localparam int MODE_SCAN = 1;

  // Another channel of the same sequence follows when the current channel is
  // above zero and either a scan runs or the mode now asks for one.
  function automatic logic walk_more(input logic scanning, input logic [1:0] mode,
                                     input logic chan_nz);
    return chan_nz && (scanning || mode[MODE_SCAN]);
  endfunction

  // A fresh sequence follows a finished one in continuous mode, or when start
  // was written again while the sequence ran.
  function automatic logic seq_repeat(input logic start, input logic rewritten,
                                      input logic [1:0] mode);
    return start && (mode[MODE_CONT] || rewritten);
  endfunction

endpackage

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
  parameter int CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;

  logic [CW-1:0] cnt;

  assign done = run && (cnt == CW'(CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || done) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < CW'(CYC))); // R3

endmodule

// File: rtl/adc_inj_latch.sv
module adc_inj_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  input  logic take,
  output logic pend
);
  // If take consumes a trigger that arrived with no request held, nothing
  // remains; a trigger beside a take of an older request stays held.
  always_ff @(posedge clk) begin
    if (!rst_n)    pend <= 1'b0;
    else if (pend) pend <= !take || trig;
    else           pend <= trig && !take;
  end

  AST_TRIG_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !(take && !pend)) |=> pend); // R13

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int WORD_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              std_wr,
  input  logic              inj_wr,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] std_q,
  output logic [WORD_W-1:0] inj_q,
  output logic              eoc,
  output logic              eoi
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      std_q <= '0;
      inj_q <= '0;
      eoc   <= 1'b0;
      eoi   <= 1'b0;
    end else begin
      eoc <= std_wr;
      eoi <= inj_wr;
      if (std_wr) std_q <= word;
      if (inj_wr) inj_q <= word;
    end
  end

  always @(posedge clk) begin
    if (rst_n) begin
      AST_SINGLE_SINK: assert (!(std_wr && inj_wr)); // R9
    end
  end

  AST_STD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !std_wr |=> $stable(std_q)); // R9

endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int CH_NUM   = 8,
  parameter int RES_W    = 10,
  parameter int CONV_CYC = 6,
  localparam int CH_W    = $clog2(CH_NUM),
  localparam int WORD_W  = CH_W + RES_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_mode,
  input  logic [CH_W-1:0]   cfg_chan,
  input  logic              cfg_start,
  input  logic              inj_trig,
  input  logic [CH_W-1:0]   inj_chan,
  input  logic [RES_W-1:0]  sample_in,
  output logic [CH_W-1:0]   conv_chan,
  output logic              busy,
  output logic              inj_req,
  output logic              start_flag,
  output logic [WORD_W-1:0] std_result,
  output logic [WORD_W-1:0] inj_result,
  output logic              eoc_irq,
  output logic              eoi_irq
);
  seq_state_e      state;
  logic [CH_W-1:0] act_chan, nxt_chan, inj_sel, prog_chan, end_chan;
  logic [1:0]      prog_mode;
  logic            prog_start, start_rewr, scan_run, nxt_valid, nxt_scan;
  logic            cnv_run, cnv_done, std_done, inj_done;
  logic            inj_hold, inj_pend, inj_take;
  logic            walk, relaunch, end_valid, end_scan, seq_end, clear_start;

  // conversion timing
  assign cnv_run  = (state != ST_IDLE);
  assign std_done = (state == ST_STD) && cnv_done;
  assign inj_done = (state == ST_INJ) && cnv_done;

  adc_conv_timer #(.CYC(CONV_CYC)) u_timer (
    .clk (clk),
    .rst_n (rst_n),
    .run (cnv_run),
    .done (cnv_done)
  );

  // injection request latch
  assign inj_pend = inj_hold || inj_trig;
  assign inj_take = inj_pend &&
                    ((state == ST_IDLE) || std_done || (inj_done && !nxt_valid));

  adc_inj_latch u_inj (
    .clk (clk),
    .rst_n (rst_n),
    .trig (inj_trig),
    .take (inj_take),
    .pend (inj_hold)
  );

  // decision at the end of a standard conversion
  always_comb begin
    walk      = walk_more(scan_run, prog_mode, act_chan != '0);
    relaunch  = seq_repeat(prog_start, start_rewr, prog_mode);
    end_valid = walk || relaunch;
    end_chan  = walk ? act_chan - 1'b1 : prog_chan;
    end_scan  = walk || prog_mode[MODE_SCAN];
  end

  assign seq_end     = std_done && !walk;
  assign clear_start = seq_end && !relaunch;

  // software-visible configuration
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prog_mode  <= '0;
      prog_chan  <= '0;
      prog_start <= 1'b0;
      start_rewr <= 1'b0;
    end else begin
      if (cfg_we) begin
        prog_mode  <= cfg_mode;
        prog_chan  <= cfg_chan;
        prog_start <= cfg_start;
      end else if (clear_start) begin
        prog_start <= 1'b0;
      end
      if (cfg_we && cfg_start && (state != ST_IDLE)) start_rewr <= 1'b1;
      else if (seq_end || (state == ST_IDLE))        start_rewr <= 1'b0;
    end
  end

  // sequencing state
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      act_chan  <= '0;
      scan_run  <= 1'b0;
      nxt_valid <= 1'b0;
      nxt_chan  <= '0;
      nxt_scan  <= 1'b0;
      inj_sel   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (inj_pend) begin
            state   <= ST_INJ;
            inj_sel <= inj_chan;
          end else if (prog_start) begin
            state    <= ST_STD;
            act_chan <= prog_chan;
            scan_run <= prog_mode[MODE_SCAN];
          end
        end
        ST_STD: begin
          if (cnv_done) begin
            if (inj_pend) begin
              state     <= ST_INJ;
              inj_sel   <= inj_chan;
              nxt_valid <= end_valid;
              nxt_chan  <= end_chan;
              nxt_scan  <= end_scan;
            end else if (end_valid) begin
              act_chan <= end_chan;
              scan_run <= end_scan;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_INJ: begin
          if (cnv_done) begin
            if (nxt_valid) begin
              state     <= ST_STD;
              act_chan  <= nxt_chan;
              scan_run  <= nxt_scan;
              nxt_valid <= 1'b0;
            end else if (inj_pend) begin
              inj_sel <= inj_chan;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign conv_chan  = (state == ST_INJ) ? inj_sel : act_chan;
  assign busy       = cnv_run;
  assign inj_req    = inj_hold || (state == ST_INJ);
  assign start_flag = prog_start;

  adc_result_bank #(.WORD_W(WORD_W)) u_res (
    .clk (clk),
    .rst_n (rst_n),
    .std_wr (std_done),
    .inj_wr (inj_done),
    .word ({conv_chan, sample_in}),
    .std_q (std_result),
    .inj_q (inj_result),
    .eoc (eoc_irq),
    .eoi (eoi_irq)
  );

  AST_EOC_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_irq |-> $past(busy)); // R2

  AST_SCAN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (std_done && walk && !inj_pend) |=>
      ((state == ST_STD) && (act_chan == $past(act_chan) - 1'b1))); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_IDLE) && !prog_start && !inj_pend) |=> (state == ST_IDLE)); // R8

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_req && !inj_done) |=> inj_req); // R10

  AST_INJ_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_INJ) && !cnv_done) |=> (state == ST_INJ)); // R12

endmodule

// File: tb/adc_seq_top_test.sv
module adc_seq_top_test;
  localparam int CH_NUM   = 8;
  localparam int RES_W    = 10;
  localparam int CONV_CYC = 6;
  localparam int CH_W     = 3;
  localparam int WORD_W   = CH_W + RES_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic              cfg_we = 1'b0, cfg_start = 1'b0, inj_trig = 1'b0;
  logic [1:0]        cfg_mode = 2'b00;
  logic [CH_W-1:0]   cfg_chan = '0, inj_chan = '0;
  logic [RES_W-1:0]  sample_in, salt = '0;
  logic [CH_W-1:0]   conv_chan;
  logic              busy, inj_req, start_flag, eoc_irq, eoi_irq;
  logic [WORD_W-1:0] std_result, inj_result;

  adc_seq_top #(.CH_NUM(CH_NUM), .RES_W(RES_W), .CONV_CYC(CONV_CYC)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cfg_chan(cfg_chan), .cfg_start(cfg_start), .inj_trig(inj_trig),
    .inj_chan(inj_chan), .sample_in(sample_in), .conv_chan(conv_chan),
    .busy(busy), .inj_req(inj_req), .start_flag(start_flag),
    .std_result(std_result), .inj_result(inj_result),
    .eoc_irq(eoc_irq), .eoi_irq(eoi_irq)
  );

  function automatic logic [RES_W-1:0] code_of(input logic [CH_W-1:0] ch,
                                               input logic [RES_W-1:0] s);
    logic [RES_W-1:0] w;
    w = RES_W'(ch);
    return (w * RES_W'(73) + RES_W'(29)) ^ s;
  endfunction

  function automatic logic [WORD_W-1:0] word_of(input int ch, input logic [RES_W-1:0] s);
    return {CH_W'(ch), code_of(CH_W'(ch), s)};
  endfunction

  assign sample_in = code_of(conv_chan, salt);

  int checks = 0, fails = 0, cyc = 0;
  logic [WORD_W-1:0] std_log[256], inj_log[256];
  int std_t[256], inj_t[256];
  int std_n = 0, inj_n = 0;
  int busy_rise_t = 0, req_rise_t = 0;
  logic busy_prev = 1'b0, req_prev = 1'b0;
  int exp_ch[64];
  int exp_n = 0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (eoc_irq && std_n < 256) begin std_log[std_n] = std_result; std_t[std_n] = cyc; std_n = std_n + 1; end
    if (eoi_irq && inj_n < 256) begin inj_log[inj_n] = inj_result; inj_t[inj_n] = cyc; inj_n = inj_n + 1; end
    if (busy && !busy_prev) busy_rise_t = cyc;
    if (inj_req && !req_prev) req_rise_t = cyc;
    busy_prev = busy;
    req_prev  = inj_req;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  task automatic wr_cfg(input logic [1:0] m, input int ch, input logic st);
    @(negedge clk);
    cfg_we = 1'b1; cfg_mode = m; cfg_chan = CH_W'(ch); cfg_start = st;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_inj(input int ch);
    @(negedge clk);
    inj_chan = CH_W'(ch); inj_trig = 1'b1;
    @(negedge clk);
    inj_trig = 1'b0;
  endtask

  task automatic wait_quiet();
    int q = 0;
    int guard = 0;
    while (q < 4 && guard < 5000) begin
      @(negedge clk);
      guard = guard + 1;
      if (!busy && !inj_req && !start_flag) q = q + 1; else q = 0;
    end
  endtask

  task automatic clear_logs();
    std_n = 0; inj_n = 0; exp_n = 0;
  endtask

  task automatic push_ch(input int ch);
    exp_ch[exp_n] = ch; exp_n = exp_n + 1;
  endtask

  task automatic push_scan(input int from);
    for (int c = from; c >= 0; c--) push_ch(c);
  endtask

  task automatic check_seq(input string tag);
    chk(std_n == exp_n, {tag, " result count"}, std_n, exp_n);
    for (int i = 0; i < exp_n && i < std_n; i++)
      chk(std_log[i] == word_of(exp_ch[i], salt), {tag, " result order"}, std_log[i],
          word_of(exp_ch[i], salt));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails = fails + 1;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    summary();
    $finish;
  end

  initial begin
    logic [WORD_W-1:0] std_keep;
    int n_clear;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !inj_req && !start_flag, "R1 flags in reset", {busy, inj_req, start_flag}, 0);
    chk(std_result == '0 && inj_result == '0, "R1 results in reset", std_result, 0);
    chk(!eoc_irq && !eoi_irq, "R1 pulses in reset", {eoc_irq, eoi_irq}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 / R3 fixed single
    salt = 10'h155; clear_logs(); push_ch(3);
    wr_cfg(2'b00, 3, 1'b1);
    wait_quiet();
    check_seq("R2 fixed single");
    chk(std_n > 0 && (std_t[0] - busy_rise_t) == CONV_CYC, "R3 latency",
        std_t[0] - busy_rise_t, CONV_CYC);
    chk(!start_flag && !busy, "R2 start cleared", {start_flag, busy}, 0);

    // R4 scan single from 5
    salt = 10'h0A3; clear_logs(); push_scan(5);
    wr_cfg(2'b10, 5, 1'b1);
    wait_quiet();
    check_seq("R4 scan down");

    // R8 idle write of scan mode without start
    clear_logs();
    wr_cfg(2'b00, 5, 1'b1); wait_quiet();
    clear_logs();
    wr_cfg(2'b10, 5, 1'b0);
    repeat (40) @(negedge clk);
    chk(std_n == 0 && !busy, "R8 no spurious scan", std_n, 0);
    wr_cfg(2'b11, 6, 1'b0);
    repeat (20) @(negedge clk);
    chk(std_n == 0 && !busy, "R8 no spurious continuous", std_n, 0);

    // R6 fixed -> scan while converting
    clear_logs(); push_scan(6);
    wr_cfg(2'b00, 6, 1'b1);
    @(negedge clk);
    wr_cfg(2'b10, 6, 1'b0);
    wait_quiet();
    check_seq("R6 fixed to scan");

    // R7 fixed: channel/start during conversion used afterwards
    clear_logs(); push_ch(1); push_ch(6);
    wr_cfg(2'b00, 1, 1'b1);
    repeat (2) @(negedge clk);
    wr_cfg(2'b00, 6, 1'b1);
    wait_quiet();
    check_seq("R7 fixed deferred");

    // R7 scan: channel/start during scan used after channel 0
    clear_logs(); push_scan(4); push_scan(2);
    wr_cfg(2'b10, 4, 1'b1);
    while (std_n < 1) @(negedge clk);
    wr_cfg(2'b10, 2, 1'b1);
    wait_quiet();
    check_seq("R7 scan deferred");

    // R5 fixed continuous
    clear_logs();
    wr_cfg(2'b01, 2, 1'b1);
    while (std_n < 3) @(negedge clk);
    wr_cfg(2'b01, 2, 1'b0);
    n_clear = std_n;
    wait_quiet();
    chk(std_n >= 3 && std_n <= n_clear + 2, "R5 continuous stop", std_n, n_clear);
    for (int i = 0; i < std_n; i++)
      chk(std_log[i] == word_of(2, salt), "R5 continuous channel", std_log[i], word_of(2, salt));
    n_clear = std_n;
    repeat (30) @(negedge clk);
    chk(std_n == n_clear && !busy, "R5 stays stopped", std_n, n_clear);

    // R5 scan continuous stops only at channel 0
    clear_logs();
    wr_cfg(2'b11, 2, 1'b1);
    while (std_n < 4) @(negedge clk);
    wr_cfg(2'b11, 2, 1'b0);
    wait_quiet();
    chk(std_n >= 6 && (std_n % 3) == 0, "R5 scan ends at ch0", std_n, 6);
    for (int i = 0; i < std_n; i++)
      chk(std_log[i] == word_of(2 - (i % 3), salt), "R5 scan repeat order", std_log[i],
          word_of(2 - (i % 3), salt));

    // R9 / R10 injection from idle
    clear_logs();
    std_keep = std_result;
    pulse_inj(7);
    chk(inj_req && busy, "R10 req and busy", {inj_req, busy}, 3);
    wait_quiet();
    chk(inj_n == 1, "R9 one injected result", inj_n, 1);
    chk(inj_result == word_of(7, salt), "R9 injected word", inj_result, word_of(7, salt));
    chk(std_result == std_keep && std_n == 0, "R9 standard untouched", std_result, std_keep);
    chk(!inj_req, "R10 req cleared", inj_req, 0);

    // R11 trigger exactly on the boundary of channel 2
    clear_logs(); push_scan(3);
    wr_cfg(2'b10, 3, 1'b1);
    do @(negedge clk); while (!eoc_irq);
    repeat (CONV_CYC - 2) @(negedge clk);
    pulse_inj(5);
    wait_quiet();
    check_seq("R11 scan complete");
    chk(inj_n == 1 && inj_log[0] == word_of(5, salt), "R11 injection kept", inj_log[0],
        word_of(5, salt));
    chk(std_n == 4 && inj_t[0] == std_t[1] + CONV_CYC, "R11 injected at boundary",
        inj_t[0], std_t[1] + CONV_CYC);
    chk(std_n == 4 && std_t[2] == inj_t[0] + CONV_CYC, "R11 scan resumes", std_t[2],
        inj_t[0] + CONV_CYC);

    // R12 software start during injection
    clear_logs();
    pulse_inj(1);
    wr_cfg(2'b00, 4, 1'b1);
    wait_quiet();
    chk(inj_n == 1 && (inj_t[0] - req_rise_t) == CONV_CYC, "R12 injection not shortened",
        inj_t[0] - req_rise_t, CONV_CYC);
    chk(std_n == 1 && std_log[0] == word_of(4, salt), "R12 held start runs", std_log[0],
        word_of(4, salt));
    chk(std_n == 1 && inj_n == 1 && std_t[0] > inj_t[0], "R12 order", std_t[0], inj_t[0]);

    // R13 trigger during a running injection
    clear_logs();
    pulse_inj(5);
    repeat (2) @(negedge clk);
    pulse_inj(5);
    wait_quiet();
    chk(inj_n == 2, "R13 two injections", inj_n, 2);
    chk(inj_n == 2 && inj_t[1] - inj_t[0] == CONV_CYC, "R13 back to back",
        inj_t[1] - inj_t[0], CONV_CYC);

    // random mix of single starts and injections
    for (int it = 0; it < 16; it++) begin
      logic [1:0] m;
      int ch, ic, dly;
      bit do_inj;
      salt = RES_W'($urandom);
      m = ($urandom % 2) ? 2'b10 : 2'b00;
      ch = int'($urandom % CH_NUM);
      ic = int'($urandom % CH_NUM);
      dly = int'($urandom % 20);
      do_inj = 1'($urandom % 2);
      clear_logs();
      if (m == 2'b10) push_scan(ch); else push_ch(ch);
      wr_cfg(m, ch, 1'b1);
      if (do_inj) begin
        repeat (dly) @(negedge clk);
        pulse_inj(ic);
      end
      wait_quiet();
      check_seq(m == 2'b10 ? "R4 random scan" : "R2 random fixed");
      chk(inj_n == int'(do_inj), "R11 random injection count", inj_n, do_inj);
      if (do_inj && inj_n > 0)
        chk(inj_log[0] == word_of(ic, salt), "R9 random injected word", inj_log[0],
            word_of(ic, salt));
    end

    summary();
    $finish;
  end
endmodule